// File: doc/BRIEF.md
# Grouped Prioritized Interrupt Controller

This block collects 192 interrupt request lines, organised as 24 groups of eight, and turns them into a single interrupt line to the processor and a readable vector that names the most urgent request. Every line passes through a two-flop synchronizer. A per-line sense bit then selects whether it triggers on a level or on an edge, and a per-line polarity bit selects which level or edge counts. A triggered line sets a sticky status bit. Software clears that bit by writing a one to it. A status bit that is still set keeps requesting service.

Software uses a byte-wide register port. Each group has four byte registers: status, enable, sense and polarity. The group blocks sit at offsets spaced four bytes apart, with a four-byte hole after the fourth group. The vector register sits in that hole at offset 0x10. The port has plain strobes: a write takes effect on the clock edge where the write strobe is high, and read data is registered on the clock edge where the read strobe is high. The port never applies back-pressure and has no handshake, so every access completes in one cycle. The interrupt output is plain control as well.

Top module: `irqc_grouped_top`

## Requirements
- R1: After reset, every enable, sense, polarity and status bit is zero, `irq_o` is low and the vector register reads 0x10.
- R2: Group g (0..23) has its registers at base = 4*g, plus 4 more when g >= 4. The status register is at base+0, enable at base+1, sense at base+2 and polarity at base+3. Source n maps to group n/8, bit n%8.
- R3: Writing a one to a status bit clears it. Writing a zero to a status bit leaves it unchanged. A status bit stays set until it is cleared. If a set event and a clear arrive in the same cycle, the set wins.
- R4: With sense bit 0 (level), the status bit is set on every cycle the synchronized input is at its active level, so clearing it while the level is still active does not keep it clear.
- R5: With sense bit 1 (edge), the status bit is set once per selected transition of the synchronized input, and a clear sticks while the input holds steady.
- R6: Polarity bit 0 selects active-high or rising-edge; polarity bit 1 selects active-low or falling-edge.
- R7: Among sources whose status and enable bits are both set, the winner is the one in the highest-numbered group, and within that group the highest bit.
- R8: The vector register at offset 0x10 reads the winner's number plus 0x10. When no source from 1 to 191 is pending it reads 0x10. Source 0 never wins.
- R9: `irq_o` is a register that equals the OR over all sources of status AND enable, one cycle after that term changes. This OR includes source 0.
- R10: Read data appears on `reg_rdata_o` after the clock edge where `reg_rd_i` is high, and is held until the next read. Offsets that no register uses read 0. Two back-to-back reads of the vector with no status change return the same value.
- R11: A change on a raw input reaches its status bit on the third rising clock edge after it is applied, and reaches `irq_o` on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_raw_i | input | 192 | Raw asynchronous interrupt request lines, bit n is source n |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
The bench builds the block with its default parameters: 24 groups of 8, a vector offset of 0x10 and 8-bit offsets. With these values the highest source (191) and the last group's registers at 0x60..0x63 can be reached, and so can the hole at 0x10..0x13 where the vector lives. Because the full width is used, the priority search spans groups far apart and bits within one group. Random configurations of sense, polarity and enable are applied against sparse input patterns, so edge and level sources of both polarities compete in the same run.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  typedef enum logic [1:0] {
    REG_STATUS   = 2'd0,
    REG_ENABLE   = 2'd1,
    REG_SENSE    = 2'd2,
    REG_POLARITY = 2'd3
  } reg_kind_e;

  // byte offset of the first register of group g; groups from 4 up skip a hole
  function automatic int grp_base(input int g, input int hole_after, input int stride);
    return stride * g + ((g >= hole_after) ? stride : 0);
  endfunction
endpackage

// File: rtl/irqc_input_cond.sv
module irqc_input_cond #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] sense_i,
  input  logic [W-1:0] pol_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= raw_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  for (genvar b = 0; b < W; b++) begin : g_bit
    logic rise, fall, lvl_act, edge_hit;
    always_comb begin
      rise     = sync_q[b] & ~prev_q[b];
      fall     = ~sync_q[b] & prev_q[b];
      lvl_act  = sync_q[b] ^ pol_i[b];
      edge_hit = pol_i[b] ? fall : rise;
      set_o[b] = sense_i[b] ? edge_hit : lvl_act;
    end
  end
endmodule

// File: rtl/irqc_group_regs.sv
module irqc_group_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_status_i,
  input  logic         wr_enable_i,
  input  logic         wr_sense_i,
  input  logic         wr_pol_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic [W-1:0] sense_o,
  output logic [W-1:0] pol_o
);
  logic [W-1:0] clr_mask;
  assign clr_mask = wr_status_i ? wdata_i : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_o <= '0;
      enable_o <= '0;
      sense_o  <= '0;
      pol_o    <= '0;
    end else begin
      status_o <= (status_o & ~clr_mask) | set_i;
      if (wr_enable_i) enable_o <= wdata_i;
      if (wr_sense_i)  sense_o  <= wdata_i;
      if (wr_pol_i)    pol_o    <= wdata_i;
    end
  end

  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_status_i && ((wdata_i & ~set_i) != '0)) |=>
      ((status_o & $past(wdata_i & ~set_i)) == '0)); // R3

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_status_i |=> ((~status_o & $past(status_o)) == '0)); // R3

  AST_SET_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((status_o & $past(set_i)) == $past(set_i))); // R4
endmodule

// File: rtl/irqc_prio_enc.sv
module irqc_prio_enc #(
  parameter int N      = 192,
  parameter int VEC_W  = 8,
  parameter int OFFSET = 16,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     pending_i,
  output logic [VEC_W-1:0] vector_o
);
  logic [IDX_W-1:0] idx;

  // ascending scan: the last hit is the highest index; source 0 is skipped
  always_comb begin
    idx = '0;
    for (int i = 1; i < N; i++) begin
      if (pending_i[i]) idx = IDX_W'(i);
    end
  end

  assign vector_o = VEC_W'(idx) + VEC_W'(OFFSET);

  AST_WINNER_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (idx != '0) |-> pending_i[idx]); // R8

  AST_NONE_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pending_i[N-1:1] != '0) |-> (vector_o != VEC_W'(OFFSET))); // R8
endmodule

// File: rtl/irqc_grouped_top.sv
module irqc_grouped_top #(
  parameter int NUM_GROUPS = 24,
  parameter int GROUP_W    = 8,
  parameter int ADDR_W     = 8,
  parameter int VEC_OFFSET = 16,
  parameter int VEC_ADDR   = 16,
  parameter int HOLE_AFTER = 4,
  localparam int NUM_SRC   = NUM_GROUPS * GROUP_W,
  localparam int STRIDE    = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] irq_raw_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [GROUP_W-1:0] reg_wdata_i,
  output logic [GROUP_W-1:0] reg_rdata_o,
  output logic               irq_o
);
  import irqc_pkg::*;

  logic [NUM_SRC-1:0] status_all, enable_all, pending_all;
  logic [GROUP_W-1:0] vector;
  logic [GROUP_W-1:0] grp_rd [NUM_GROUPS];
  logic [NUM_GROUPS-1:0] grp_hit;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int BASE = grp_base(g, HOLE_AFTER, STRIDE);
    logic [GROUP_W-1:0] set_v, st, en, se, po;
    logic hit;
    reg_kind_e kind;

    assign hit  = (reg_addr_i >= ADDR_W'(BASE)) && (reg_addr_i < ADDR_W'(BASE + STRIDE));
    assign kind = reg_kind_e'(reg_addr_i[1:0] - 2'(BASE));

    irqc_input_cond #(.W(GROUP_W)) u_cond (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw_i   (irq_raw_i[g*GROUP_W +: GROUP_W]),
      .sense_i (se),
      .pol_i   (po),
      .set_o   (set_v)
    );

    irqc_group_regs #(.W(GROUP_W)) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_status_i (reg_wr_i && hit && kind == REG_STATUS),
      .wr_enable_i (reg_wr_i && hit && kind == REG_ENABLE),
      .wr_sense_i  (reg_wr_i && hit && kind == REG_SENSE),
      .wr_pol_i    (reg_wr_i && hit && kind == REG_POLARITY),
      .wdata_i     (reg_wdata_i),
      .set_i       (set_v),
      .status_o    (st),
      .enable_o    (en),
      .sense_o     (se),
      .pol_o       (po)
    );

    always_comb begin
      unique case (kind)
        REG_STATUS:   grp_rd[g] = st;
        REG_ENABLE:   grp_rd[g] = en;
        REG_SENSE:    grp_rd[g] = se;
        default:      grp_rd[g] = po;
      endcase
    end

    assign grp_hit[g] = hit;
    assign status_all[g*GROUP_W +: GROUP_W] = st;
    assign enable_all[g*GROUP_W +: GROUP_W] = en;
  end

  assign pending_all = status_all & enable_all;

  irqc_prio_enc #(.N(NUM_SRC), .VEC_W(GROUP_W), .OFFSET(VEC_OFFSET)) u_enc (
    .clk       (clk),
    .rst_n     (rst_n),
    .pending_i (pending_all),
    .vector_o  (vector)
  );

  logic [GROUP_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_addr_i == ADDR_W'(VEC_ADDR)) rd_mux = vector;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (grp_hit[g]) rd_mux = grp_rd[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata_o <= '0;
      irq_o       <= 1'b0;
    end else begin
      if (reg_rd_i) reg_rdata_o <= rd_mux;
      irq_o <= |pending_all;
    end
  end

  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (irq_o == $past(|pending_all))); // R9

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd_i |=> $stable(reg_rdata_o)); // R10

  AST_HIT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_hit)); // R2
endmodule

// File: tb/irqc_grouped_top_test.sv
`timescale 1ns/1ps
module irqc_grouped_top_test;
  localparam int NG = 24;
  localparam int NS = 192;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NS-1:0] raw = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic irq;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irqc_grouped_top uut (
    .clk(clk), .rst_n(rst_n), .irq_raw_i(raw),
    .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] gaddr(input int g);
    return 8'(4 * g + ((g >= 4) ? 4 : 0));
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); reg_rd = 1'b1; addr = a;
    @(negedge clk); reg_rd = 1'b0; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; raw = '0;
    idle(2); rst_n = 1'b1; idle(1);
  endtask

  // expected status after config at raw=0 then raw=r (sense 1 = edge, pol 1 = low/fall)
  function automatic logic [7:0] exp_status(input logic [7:0] se, input logic [7:0] po,
                                            input logic [7:0] r);
    return (se & ~po & r) | (~se & (po | r));
  endfunction

  logic [7:0] m_en [NG];
  logic [7:0] m_se [NG];
  logic [7:0] m_po [NG];
  logic [7:0] m_st [NG];

  function automatic logic [7:0] exp_vector();
    for (int n = NS - 1; n >= 1; n--) begin
      if (m_st[n / 8][n % 8] && m_en[n / 8][n % 8]) return 8'(n + 16);
    end
    return 8'h10;
  endfunction

  function automatic logic exp_irq();
    logic any = 1'b0;
    for (int g = 0; g < NG; g++) any |= |(m_st[g] & m_en[g]);
    return any;
  endfunction

  logic [7:0] v, v2;

  initial begin
    void'($urandom(32'd2024));
    idle(2); rst_n = 1'b1; idle(2);

    // R1 reset state
    chk("R1 irq after reset", {7'd0, irq}, 8'h00);
    rd(8'h10, v); chk("R1 vector after reset", v, 8'h10);
    rd(gaddr(23) + 8'd1, v); chk("R1 enable g23 after reset", v, 8'h00);
    rd(gaddr(0), v); chk("R1 status g0 after reset", v, 8'h00);
    // R10 unmapped offsets
    rd(8'h13, v); chk("R10 unmapped 0x13", v, 8'h00);
    rd(8'h7f, v); chk("R10 unmapped 0x7f", v, 8'h00);
    // R2 map
    wr(gaddr(4) + 8'd1, 8'ha5); rd(8'd21, v); chk("R2 enable g4 at 0x15", v, 8'ha5);
    rd(8'h11, v); chk("R2 hole 0x11", v, 8'h00);
    wr(8'd14, 8'h3c); rd(gaddr(3) + 8'd2, v); chk("R2 sense g3 at 0x0e", v, 8'h3c);
    wr(8'd21, 8'h00); wr(8'd14, 8'h00);

    // R11/R5: source 43 edge rising (group 5 bit 3)
    wr(gaddr(5) + 8'd2, 8'h08); wr(gaddr(5) + 8'd1, 8'h08);
    @(negedge clk); raw[43] = 1'b1;
    idle(3); chk("R11 irq low after 3 edges", {7'd0, irq}, 8'h00);
    idle(1); chk("R11 R9 irq high after 4 edges", {7'd0, irq}, 8'h01);
    rd(gaddr(5), v); chk("R5 edge status g5", v, 8'h08);
    rd(8'h10, v); chk("R8 vector source 43", v, 8'd59);
    wr(gaddr(5), 8'h00); rd(gaddr(5), v); chk("R3 write zero keeps status", v, 8'h08);
    wr(gaddr(5), 8'h08); idle(3);
    rd(gaddr(5), v); chk("R5 clear sticks on edge", v, 8'h00);
    chk("R9 irq low after clear", {7'd0, irq}, 8'h00);

    // R4: source 100 level high (group 12 bit 4)
    wr(gaddr(12) + 8'd1, 8'h10);
    @(negedge clk); raw[100] = 1'b1; idle(5);
    rd(8'h10, v); chk("R4 vector source 100", v, 8'd116);
    wr(gaddr(12), 8'h10); idle(3);
    rd(gaddr(12), v); chk("R4 level re-sets after clear", v, 8'h10);

    // R6: source 150 active-low level (group 18 bit 6)
    wr(gaddr(18) + 8'd3, 8'h40); wr(gaddr(18) + 8'd1, 8'h40); idle(5);
    rd(gaddr(18), v); chk("R6 active-low level sets", v, 8'h40);
    rd(8'h10, v); chk("R7 higher group wins", v, 8'd166);
    rd(8'h10, v2); chk("R10 back-to-back vector", v2, v);

    // R7 within a group
    @(negedge clk); raw[96] = 1'b1;
    wr(gaddr(12) + 8'd1, 8'h11); wr(gaddr(18) + 8'd1, 8'h00); idle(5);
    rd(8'h10, v); chk("R7 higher bit wins", v, 8'd116);
    wr(gaddr(12) + 8'd1, 8'h01); rd(8'h10, v); chk("R7 lower bit alone", v, 8'd112);

    // R8: source 0 never wins but drives irq
    wr(gaddr(12) + 8'd1, 8'h00);
    wr(8'd3, 8'h01); wr(8'd1, 8'h01); idle(5);
    rd(8'h10, v); chk("R8 source 0 reads as none", v, 8'h10);
    chk("R9 source 0 raises irq", {7'd0, irq}, 8'h01);

    // random configurations
    do_reset();
    for (int t = 0; t < 30; t++) begin
      logic [NS-1:0] r;
      @(negedge clk); raw = '0; idle(4);
      for (int g = 0; g < NG; g++) begin
        wr(gaddr(g) + 8'd2, 8'hff); wr(gaddr(g) + 8'd3, 8'h00); wr(gaddr(g) + 8'd1, 8'h00);
      end
      for (int g = 0; g < NG; g++) wr(gaddr(g), 8'hff);
      for (int g = 0; g < NG; g++) begin
        m_en[g] = 8'($urandom);
        m_se[g] = 8'($urandom);
        m_po[g] = 8'($urandom);
        r[g*8 +: 8] = 8'($urandom & $urandom & $urandom);
        if ((t % 3) == 0 && g < 20) r[g*8 +: 8] = 8'h00;
        wr(gaddr(g) + 8'd2, m_se[g]); wr(gaddr(g) + 8'd3, m_po[g]); wr(gaddr(g) + 8'd1, m_en[g]);
      end
      @(negedge clk); raw = r; idle(6);
      for (int g = 0; g < NG; g++) m_st[g] = exp_status(m_se[g], m_po[g], r[g*8 +: 8]);
      rd(8'h10, v); chk("R7 R8 random vector", v, exp_vector());
      chk("R9 random irq", {7'd0, irq}, {7'd0, exp_irq()});
      for (int k = 0; k < 3; k++) begin
        int g = int'($urandom % NG);
        rd(gaddr(g), v); chk("R4 R5 R6 random status", v, m_st[g]);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule